// File: doc/BRIEF.md
# Bipolar Rail Charge-Pulse Scheduler

This block is the digital core of a single-inductor converter that feeds two rails of opposite polarity. It splits time into fixed charge periods of `2*HALF_CYC` clocks, counted on the main converter clock so that every period edge lines up with that clock. In a period that carries a pulse, both power switches conduct during the first half so that the inductor charges. In the second half, one switch opens, and the one that opens decides which rail receives the stored energy.

At the last cycle of every period the scheduler samples its inputs and picks what the next period does: a negative-rail pulse, a positive-rail pulse, or nothing. A rail whose comparator reports no need is passed over. When both rails ask for charge, they take turns. If the zero-current detector shows that the inductor still carries current, the whole next period stays empty, and this repeats one period at a time until the current reaches zero. Disabling the block stops new pulses but never cuts one short.

Top module: `bipolar_pulse_sched`

## Requirements
- R1: Periods last 2*HALF_CYC clocks, with the first period beginning on the first clock after reset is released. The inputs seen on the last clock of a period alone decide what the next period does, and nothing changes a period once it has begun.
- R2: In a pulse period, `gate_n` and `gate_p` are both 1 for exactly the first HALF_CYC clocks.
- R3: In the second half of a negative-rail pulse, `gate_n`=1, `gate_p`=0 and `tgt_pos`=0.
- R4: In the second half of a positive-rail pulse, `gate_n`=0, `gate_p`=1 and `tgt_pos`=1.
- R5: While both rails keep requesting and the inductor is idle, consecutive periods alternate negative, positive, negative, and so on, with no empty period between them.
- R6: A rail without a request is skipped. If only one rail requests, that rail receives a pulse in every period.
- R7: If `zc_idle` is 0 at the decision clock, the next period has both gates at 0.
- R8: When both rails request, the rail opposite to the most recently served one is chosen. After reset, the first rail chosen in this case is the negative rail.
- R9: If `en` is 0 at the decision clock, the next period has both gates at 0. A pulse that has already begun runs its full period regardless of `en`.
- R10: A positive request (`req_pos`=1) has no effect while `pos_en` is 0.
- R11: While in reset, `gate_n`, `gate_p` and `tgt_pos` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable, sampled at each period's decision clock |
| req_neg | input | 1 | Negative rail needs charge |
| req_pos | input | 1 | Positive rail needs charge |
| pos_en | input | 1 | Enables service of the positive rail |
| zc_idle | input | 1 | Inductor current has reached zero |
| gate_n | output | 1 | Low-side (N) switch control, 1 = on |
| gate_p | output | 1 | High-side (P) switch control, 1 = on |
| tgt_pos | output | 1 | 1 while a positive-rail pulse is in progress |

## Verification
The assertions check the gate pairing on every cycle. Both switches must turn on together, the first half must last exactly HALF_CYC clocks, and each single-switch tail must agree with `tgt_pos`. They also check that a disabled block, a busy inductor, or an ineligible positive-only request leaves an idle scheduler idle. The choice of rail over a series of periods cannot be judged from a single cycle, so it is left to the bench scenarios. These cover strict alternation, one-rail streaks, the opposite-rail rule after a gap, and a pulse that runs to completion after the enable drops.

// File: rtl/bps_pkg.sv
// Shared types for the bipolar pulse scheduler.
package bps_pkg;
    // Rail served by a charge pulse; the encoding is also the tgt_pos value.
    typedef enum logic {
        RAIL_NEG = 1'b0,
        RAIL_POS = 1'b1
    } rail_e;
endpackage

// File: rtl/bps_phase_ctr.sv
// Period phase counter.
// Counts 0..2*HALF_CYC-1 on the main clock from reset release and flags the
// decision clock (last of the period) and the second half.
// Assumes HALF_CYC >= 1.
module bps_phase_ctr #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic last_cyc,
    output logic second_half
);
    localparam int PERIOD = 2 * HALF_CYC;
    localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;

    // Advance the phase, wrapping at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (last_cyc) cnt <= '0;
        else               cnt <= cnt + CW'(1);
    end

    assign last_cyc    = (cnt == CW'(PERIOD - 1));
    assign second_half = (cnt >= CW'(HALF_CYC));
endmodule

// File: rtl/bps_rail_arbiter.sv
// Rail arbiter (combinational).
// Decides whether the next period carries a pulse and for which rail.
// Assumes its result is used only on the decision clock.
module bps_rail_arbiter
    import bps_pkg::*;
(
    input  logic  en,
    input  logic  zc_idle,
    input  logic  req_neg,
    input  logic  req_pos,
    input  logic  pos_en,
    input  rail_e last_rail,
    output logic  start,
    output rail_e pick
);
    logic want_n;
    logic want_p;

    // Mask the positive request and gate on enable plus zero current.
    always_comb begin
        want_n = req_neg;
        want_p = req_pos & pos_en;
        start  = en & zc_idle & (want_n | want_p);
    end

    // Choose the rail; contention goes to the rail not served last.
    always_comb begin
        if (want_n && want_p)
            pick = (last_rail == RAIL_POS) ? RAIL_NEG : RAIL_POS;
        else if (want_p)
            pick = RAIL_POS;
        else
            pick = RAIL_NEG;
    end
endmodule

// File: rtl/bps_gate_drive.sv
// Pulse state and gate decode.
// Latches the decision at each period boundary and decodes both switch
// controls from the held rail and the phase half. The held rail doubles as
// the last-served memory, reset to positive so the negative rail wins the
// first contention.
module bps_gate_drive
    import bps_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  last_cyc,
    input  logic  second_half,
    input  logic  start,
    input  rail_e pick,
    output logic  gate_n,
    output logic  gate_p,
    output logic  tgt_pos,
    output rail_e last_rail
);
    logic  active;
    rail_e rail;

    // Commit the next period's plan only at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            rail   <= RAIL_POS;
        end else if (last_cyc) begin
            active <= start;
            if (start) rail <= pick;
        end
    end

    // Both switches on in the first half; in the second half the one for the target rail stays on.
    always_comb begin
        gate_n  = active & (!second_half | (rail == RAIL_NEG));
        gate_p  = active & (!second_half | (rail == RAIL_POS));
        tgt_pos = active & (rail == RAIL_POS);
    end

    assign last_rail = rail;
endmodule

// File: rtl/bipolar_pulse_sched.sv
// Bipolar rail charge-pulse scheduler (top).
// One charge pulse per period of 2*HALF_CYC main clocks. The rails alternate
// or are skipped, and empty periods are inserted while the inductor is not at
// zero current. Inputs are assumed synchronous to clk.
module bipolar_pulse_sched
    import bps_pkg::*;
#(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req_neg,
    input  logic req_pos,
    input  logic pos_en,
    input  logic zc_idle,
    output logic gate_n,
    output logic gate_p,
    output logic tgt_pos
);
    logic  last_cyc;
    logic  second_half;
    logic  start;
    rail_e pick;
    rail_e last_rail;

    bps_phase_ctr #(.HALF_CYC(HALF_CYC)) i_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .last_cyc    (last_cyc),
        .second_half (second_half)
    );

    bps_rail_arbiter i_arb (
        .en        (en),
        .zc_idle   (zc_idle),
        .req_neg   (req_neg),
        .req_pos   (req_pos),
        .pos_en    (pos_en),
        .last_rail (last_rail),
        .start     (start),
        .pick      (pick)
    );

    bps_gate_drive i_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .last_cyc    (last_cyc),
        .second_half (second_half),
        .start       (start),
        .pick        (pick),
        .gate_n      (gate_n),
        .gate_p      (gate_p),
        .tgt_pos     (tgt_pos),
        .last_rail   (last_rail)
    );
endmodule

// File: rtl/bps_sched_chk.sv
// Protocol checker for bipolar_pulse_sched, attached by bind.
// Observes ports only.
module bps_sched_chk #(
    parameter int HALF_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic req_neg,
    input logic pos_en,
    input logic zc_idle,
    input logic gate_n,
    input logic gate_p,
    input logic tgt_pos
);
    localparam int CW = $clog2(HALF_CYC + 2);

    logic [CW-1:0] both_cnt;

    // Length of the current run of both-on cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                both_cnt <= '0;
        else if (gate_n && gate_p) both_cnt <= both_cnt + CW'(1);
        else                       both_cnt <= '0;
    end

    // R2
    n_rise_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_n) |-> gate_p);
    // R2
    p_rise_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_p) |-> gate_n);
    // R2
    first_half_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_n && gate_p) |-> (both_cnt < CW'(HALF_CYC)));
    // R2
    first_half_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(gate_n && gate_p) && both_cnt != '0) |-> (both_cnt == CW'(HALF_CYC)));
    // R3
    neg_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_n && !gate_p) |-> !tgt_pos);
    // R4
    pos_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_p && !gate_n) |-> tgt_pos);
    // R1
    tail_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_n ^ gate_p) |-> $stable(tgt_pos));
    // R9
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !gate_n && !gate_p) |=> (!gate_n && !gate_p));
    // R7
    zc_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!zc_idle && !gate_n && !gate_p) |=> (!gate_n && !gate_p));
    // R10
    pos_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pos_en && !req_neg && !gate_n && !gate_p) |=> (!gate_n && !gate_p));
endmodule

bind bipolar_pulse_sched bps_sched_chk #(.HALF_CYC(HALF_CYC)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .req_neg (req_neg),
    .pos_en  (pos_en),
    .zc_idle (zc_idle),
    .gate_n  (gate_n),
    .gate_p  (gate_p),
    .tgt_pos (tgt_pos)
);

// File: tb/test_bipolar_pulse_sched.sv
// Scoreboard bench: the driver holds inputs for one period and queues the
// expected kind of the following period (0 idle, 1 negative, 2 positive);
// the monitor samples each period's halves and compares.
module test_bipolar_pulse_sched;
    localparam int CLK_P  = 10;
    localparam int HALF   = 2;
    localparam int PERIOD = 2 * HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, req_neg = 1'b0, req_pos = 1'b0, pos_en = 1'b0, zc_idle = 1'b0;
    logic gate_n, gate_p, tgt_pos;

    int    n_chk = 0;
    int    n_err = 0;
    int    exp_q[$];
    string tag_q[$];
    int    m_last = 2;
    bit    run = 1'b0;
    bit    done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bipolar_pulse_sched #(.HALF_CYC(HALF)) i_bipolar_pulse_sched (
        .clk(clk), .rst_n(rst_n), .en(en), .req_neg(req_neg), .req_pos(req_pos),
        .pos_en(pos_en), .zc_idle(zc_idle), .gate_n(gate_n), .gate_p(gate_p),
        .tgt_pos(tgt_pos)
    );

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Hold inputs for one period; queue what the following period must be.
    task automatic drive(input logic e, input logic z, input logic rn,
                         input logic rp, input logic pe, input string tag);
        int  k;
        logic wn, wp;
        en = e; zc_idle = z; req_neg = rn; req_pos = rp; pos_en = pe;
        wn = rn; wp = rp & pe;
        if (!(e && z) || !(wn || wp)) k = 0;
        else if (wn && wp)            k = (m_last == 2) ? 1 : 2;
        else                          k = wp ? 2 : 1;
        if (k != 0) m_last = k;
        exp_q.push_back(k);
        tag_q.push_back(tag);
        repeat (PERIOD) @(negedge clk);
    endtask

    // Monitor: sample the first and second half of each period.
    initial begin : monitor
        int   j;
        logic h1n, h1p;
        int   k;
        string tg;
        j = 0; h1n = 1'b0; h1p = 1'b0;
        wait (run);
        forever begin
            if (j % PERIOD == 0) begin
                h1n = gate_n; h1p = gate_p;
            end
            if (j % PERIOD == HALF && exp_q.size() > 0) begin
                k  = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk(tg, "first_half gate_n", h1n, k != 0);
                chk(tg, "first_half gate_p", h1p, k != 0);
                chk(tg, "second_half gate_n", gate_n, k == 1);
                chk(tg, "second_half gate_p", gate_p, k == 2);
                chk(tg, "tgt_pos", tgt_pos, k == 2);
            end
            @(negedge clk);
            j++;
        end
    end

    initial begin : watchdog
        #(CLK_P * 5000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "reset gate_n", gate_n, 1'b0);
        chk("R11", "reset gate_p", gate_p, 1'b0);
        chk("R11", "reset tgt_pos", tgt_pos, 1'b0);
        rst_n = 1'b1;
        exp_q.push_back(0); tag_q.push_back("R1");   // period 0 follows reset idle
        run = 1'b1;
        drive(1, 1, 0, 0, 1, "R6");   // no request: idle
        drive(1, 1, 1, 1, 1, "R8");   // first contention goes negative
        drive(1, 1, 1, 1, 1, "R5");
        drive(1, 1, 1, 1, 1, "R5");
        drive(1, 1, 1, 1, 1, "R5");
        drive(1, 1, 1, 0, 1, "R6");   // only negative requests
        drive(1, 1, 1, 0, 1, "R6");
        drive(1, 0, 1, 1, 1, "R7");   // inductor busy: empty period
        drive(1, 0, 1, 1, 1, "R7");
        drive(1, 1, 1, 1, 1, "R8");   // opposite of last (negative) -> positive
        drive(1, 1, 0, 1, 0, "R10");  // positive masked: idle
        drive(1, 1, 1, 1, 0, "R10");  // masked positive ignored: negative
        drive(1, 1, 0, 1, 1, "R4");
        drive(0, 1, 1, 1, 1, "R9");   // positive pulse runs while disabled
        drive(0, 1, 1, 1, 1, "R9");
        drive(1, 1, 1, 1, 1, "R3");   // last positive -> negative
        drive(1, 0, 1, 1, 1, "R1");   // busy during a running pulse
        drive(1, 1, 0, 1, 1, "R2");
        drive(1, 1, 0, 0, 0, "R1");
        wait (exp_q.size() == 0);
        repeat (PERIOD) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule